// File: doc/BRIEF.md
# Adjustable-Rate Nanosecond Time Counter

This block keeps a free-running time value in nanoseconds for precision time stamping. On each reference clock cycle, while counting is enabled, the count grows by a programmable step. The step is normally the base increment, which software sets to one billion divided by the reference clock frequency. At a programmable interval the step is replaced by a separate correction increment. A correction larger than the base speeds the clock up and a smaller one slows it down, so the frequency is trimmed without any fractional accumulator.

The count can fold back at a programmable wrap period. A period of 2^31 gives a 31-bit time base. Each wrap can raise a one-cycle event pulse for the compare channels. Software uses a small word-addressed register port. Through it, software starts and stops the counter, loads a new time, restarts from zero, and sets the base increment, the correction increment, the correction interval and the wrap period. The live count cannot be read directly while it moves. Software first sets a capture bit, and the capture register then keeps a snapshot that it can read at leisure.

Top module: `ns_timebase`

## Requirements
- R1: After reset every register reads zero, except the wrap period, which reads 0x8000_0000. The count and the capture register are zero.
- R2: The count advances only while control bit 0 is set. Each step adds the base increment, held in bits 6:0 of the increment register (address 2). While bit 0 is clear, the count holds.
- R3: The correction-interval register (address 3) holds an interval minus one, P. Every (P+1)th step adds the correction increment from bits 14:8 of the increment register in place of the base. With P=0 every step is a correction step.
- R4: While the correction increment is zero, every step adds the base increment, whatever the value of P.
- R5: Writing control (address 0) with bit 11 set copies the count into the capture register on the next clock. Bit 11 then clears by itself, and control reads 0 once the capture is done. The capture register reads at address 1.
- R6: The capture register keeps its value while the counter runs, until the next capture.
- R7: Writing control with bit 9 set zeroes the count and the correction-interval counter on that clock edge, even while counting. Bit 9 always reads 0.
- R8: A write to address 1 loads the written value into the count on that edge, ahead of the increment.
- R9: While either of control bits 5:4 is set and the wrap period (address 4) is nonzero, a step whose sum reaches or passes the period stores the sum minus the period. Otherwise the count wraps modulo 2^32.
- R10: When control bit 7 is set, a wrapping step raises `wrap_evt` for exactly one cycle after that edge. While bit 7 is clear, no pulse appears.
- R11: `rd_data` shows the register chosen by `rd_addr` one clock later. Registers that were written read back their stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Registered read data |
| wrap_evt | output | 1 | One-cycle pulse after a wrapping step |

## Verification
A wrong correction-interval count shows up only as a captured value that is off by the difference between the two increments. The count is therefore measured over runs of exact, known length, long enough to include two correction steps, and checked to the nanosecond. A bad wrap comparison or a bad event gate shows in the very next capture, or as a missing or extra pulse within one cycle of the wrapping edge. A stuck capture bit shows in the control readback two cycles after the request.

// File: rtl/ntb_pkg.sv
package ntb_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TIME = 3'd1;
  localparam logic [ADDR_W-1:0] A_INC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CPER = 3'd3;
  localparam logic [ADDR_W-1:0] A_WPER = 3'd4;

  // control bit positions, decoded by software
  localparam int B_EN      = 0;
  localparam int B_WRAP_LO = 4;
  localparam int B_WRAP_HI = 5;
  localparam int B_EVT     = 7;
  localparam int B_RESTART = 9;
  localparam int B_CAPTURE = 11;

  // lsb of the correction increment inside the increment register
  localparam int CORR_LSB = 8;

  typedef struct packed {
    logic       evt;
    logic [1:0] wrap;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/ntb_regs.sv
module ntb_regs #(
  parameter int CW = 32,
  parameter int IW = 7,
  parameter logic [CW-1:0] DEF_PERIOD = 32'h8000_0000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ntb_pkg::ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]             wr_data,
  output ntb_pkg::ctrl_t            ctrl_q,
  output logic [IW-1:0]             inc_norm_q,
  output logic [IW-1:0]             inc_corr_q,
  output logic [CW-1:0]             cper_q,
  output logic [CW-1:0]             wper_q,
  output logic                      cap_pend_q,
  output logic                      restart,
  output logic                      load,
  output logic [CW-1:0]             load_val
);
  import ntb_pkg::*;

  logic wr_ctrl;
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign restart  = wr_ctrl && wr_data[B_RESTART];
  assign load     = wr_en && (wr_addr == A_TIME);
  assign load_val = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      inc_norm_q <= '0;
      inc_corr_q <= '0;
      cper_q     <= '0;
      wper_q     <= DEF_PERIOD;
      cap_pend_q <= 1'b0;
    end else begin
      cap_pend_q <= wr_ctrl && wr_data[B_CAPTURE];
      if (wr_ctrl) begin
        ctrl_q.en   <= wr_data[B_EN];
        ctrl_q.wrap <= wr_data[B_WRAP_HI:B_WRAP_LO];
        ctrl_q.evt  <= wr_data[B_EVT];
      end
      if (wr_en && (wr_addr == A_INC)) begin
        inc_norm_q <= wr_data[IW-1:0];
        inc_corr_q <= wr_data[CORR_LSB +: IW];
      end
      if (wr_en && (wr_addr == A_CPER)) cper_q <= wr_data;
      if (wr_en && (wr_addr == A_WPER)) wper_q <= wr_data;
    end
  end
endmodule

// File: rtl/ntb_step.sv
module ntb_step #(
  parameter int CW = 32,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          clr,
  input  logic [CW-1:0] cper,
  input  logic [IW-1:0] inc_norm,
  input  logic [IW-1:0] inc_corr,
  output logic [IW-1:0] step,
  output logic [CW-1:0] ic_q
);
  logic corr_due;
  logic use_corr;

  assign corr_due = (ic_q >= cper);
  assign use_corr = corr_due && (inc_corr != '0);
  assign step     = use_corr ? inc_corr : inc_norm;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ic_q <= '0;
    end else if (adv) begin
      if (corr_due) ic_q <= '0;
      else          ic_q <= ic_q + 1'b1;
    end
  end
endmodule

// File: rtl/ntb_core.sv
module ntb_core #(
  parameter int CW = 32,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wrap_on,
  input  logic          evt_en,
  input  logic [CW-1:0] wper,
  input  logic [IW-1:0] step,
  input  logic          restart,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          cap_pend,
  output logic          adv,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cap_q,
  output logic          wrap_evt_q
);
  localparam int SW = CW + 1;

  logic [SW-1:0] sum;
  logic [SW-1:0] folded;
  logic          wrap_hit;
  logic [CW-1:0] nxt;

  assign adv      = en && !restart && !load;
  assign sum      = {1'b0, cnt_q} + SW'(step);
  assign wrap_hit = wrap_on && (wper != '0) && (sum >= {1'b0, wper});
  assign folded   = sum - {1'b0, wper};
  assign nxt      = wrap_hit ? folded[CW-1:0] : sum[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      cap_q      <= '0;
      wrap_evt_q <= 1'b0;
    end else begin
      if (restart)   cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (en)   cnt_q <= nxt;
      if (cap_pend) cap_q <= cnt_q;
      wrap_evt_q <= evt_en && adv && wrap_hit;
    end
  end
endmodule

// File: rtl/ns_timebase.sv
module ns_timebase #(
  parameter int CW = 32,
  parameter int IW = 7,
  parameter logic [CW-1:0] DEF_PERIOD = 32'h8000_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ntb_pkg::ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]              wr_data,
  input  logic [ntb_pkg::ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]              rd_data,
  output logic                       wrap_evt
);
  import ntb_pkg::*;

  ctrl_t         ctrl_q;
  logic [IW-1:0] inc_norm_q, inc_corr_q, step;
  logic [CW-1:0] cper_q, wper_q, load_val, cnt_q, cap_q, ic_q;
  logic          cap_pend_q, restart, load, adv;
  logic [CW-1:0] rd_v;

  ntb_regs #(.CW(CW), .IW(IW), .DEF_PERIOD(DEF_PERIOD)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .inc_norm_q(inc_norm_q), .inc_corr_q(inc_corr_q),
    .cper_q(cper_q), .wper_q(wper_q), .cap_pend_q(cap_pend_q),
    .restart(restart), .load(load), .load_val(load_val)
  );

  ntb_step #(.CW(CW), .IW(IW)) u_step (
    .clk(clk), .rst(rst), .adv(adv), .clr(restart), .cper(cper_q),
    .inc_norm(inc_norm_q), .inc_corr(inc_corr_q), .step(step), .ic_q(ic_q)
  );

  ntb_core #(.CW(CW), .IW(IW)) u_core (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .wrap_on(|ctrl_q.wrap),
    .evt_en(ctrl_q.evt), .wper(wper_q), .step(step), .restart(restart),
    .load(load), .load_val(load_val), .cap_pend(cap_pend_q), .adv(adv),
    .cnt_q(cnt_q), .cap_q(cap_q), .wrap_evt_q(wrap_evt)
  );

  always_comb begin
    rd_v = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_v[B_EN]                  = ctrl_q.en;
        rd_v[B_WRAP_HI:B_WRAP_LO]   = ctrl_q.wrap;
        rd_v[B_EVT]                 = ctrl_q.evt;
        rd_v[B_CAPTURE]             = cap_pend_q;
      end
      A_TIME: rd_v = cap_q;
      A_INC: begin
        rd_v[IW-1:0]        = inc_norm_q;
        rd_v[CORR_LSB +: IW] = inc_corr_q;
      end
      A_CPER:  rd_v = cper_q;
      A_WPER:  rd_v = wper_q;
      default: rd_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_v;
  end
endmodule

// File: rtl/ntb_checker.sv
module ntb_checker #(
  parameter int CW = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [ntb_pkg::ADDR_W-1:0] wr_addr,
  input logic [CW-1:0]              wr_data,
  input logic                       en,
  input logic                       evt_en,
  input logic [CW-1:0]              cnt,
  input logic [CW-1:0]              ic,
  input logic                       cap_pend,
  input logic [CW-1:0]              cap_val,
  input logic                       wrap_evt
);
  import ntb_pkg::*;

  logic wr_ctrl;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wr_data[B_RESTART]) |=> (cnt == '0 && ic == '0));

  // R2
  hold_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_en) |=> $stable(cnt));

  // R5
  capture_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_pend && !(wr_ctrl && wr_data[B_CAPTURE])) |=> !cap_pend);

  // R5
  capture_copy_chk: assert property (@(posedge clk) disable iff (rst)
    cap_pend |=> (cap_val == $past(cnt)));

  // R6
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_pend |=> $stable(cap_val));

  // R10
  evt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |-> $past(evt_en));
endmodule

bind ns_timebase ntb_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .en(ctrl_q.en), .evt_en(ctrl_q.evt), .cnt(cnt_q), .ic(ic_q),
  .cap_pend(cap_pend_q), .cap_val(cap_q), .wrap_evt(wrap_evt)
);

// File: tb/ns_timebase_test.sv
module ns_timebase_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wrap_evt;

  ns_timebase uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wrap_evt(wrap_evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    pulses = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && wrap_evt) pulses++;

  // monitor: compares the registered read data when it is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      n_chk++;
      if (rd_data !== q[0].exp) begin
        n_fail++;
        $display("FAIL %s: rd_data actual 0x%08h expected 0x%08h",
                 q[0].tag, rd_data, q[0].exp);
      end
      void'(q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    rd_addr = a;
    it.due = cyc + 1; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts for exactly n steps, then stops and captures
  task automatic run(input logic [31:0] ctrl, input int n);
    wr(3'd0, ctrl);
    idle(n - 1);
    wr(3'd0, 32'h800);
    idle(2);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, 32'h0, "R1");
    rd(3'd1, 32'h0, "R1");
    rd(3'd2, 32'h0, "R1");
    rd(3'd3, 32'h0, "R1");
    rd(3'd4, 32'h8000_0000, "R1");
    // R8 load, R5 capture and self-clear
    wr(3'd1, 32'd1234);
    wr(3'd0, 32'h800);
    idle(2);
    rd(3'd1, 32'd1234, "R8");
    rd(3'd0, 32'h0, "R5");
    // R2 base increment over ten steps
    wr(3'd2, 32'h8);
    wr(3'd1, 32'd0);
    run(32'h1, 10);
    rd(3'd1, 32'd80, "R2");
    rd(3'd2, 32'h8, "R11");
    // R6 capture held while running; R2 stopped counter holds
    wr(3'd0, 32'h1);
    idle(5);
    wr(3'd0, 32'h0);
    rd(3'd1, 32'd80, "R6");
    idle(4);
    wr(3'd0, 32'h800);
    idle(2);
    rd(3'd1, 32'd128, "R2");
    // R3 correction every 4th step: 8*8 + 2*12
    wr(3'd2, 32'h0C08);
    wr(3'd3, 32'd3);
    wr(3'd0, 32'h200);
    run(32'h1, 10);
    rd(3'd1, 32'd88, "R3");
    rd(3'd3, 32'd3, "R11");
    rd(3'd2, 32'h0C08, "R11");
    // R3 interval value zero: correction on every step
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h200);
    run(32'h1, 5);
    rd(3'd1, 32'd60, "R3");
    // R4 zero correction increment
    wr(3'd2, 32'h8);
    wr(3'd3, 32'd2);
    wr(3'd0, 32'h200);
    run(32'h1, 6);
    rd(3'd1, 32'd48, "R4");
    // R9 wrap at 100 with R10 event enabled
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd100);
    wr(3'd0, 32'h200);
    p0 = pulses;
    run(32'hB1, 13);
    rd(3'd1, 32'd4, "R9");
    check(pulses - p0, 1, "R10");
    // R9 wrap with R10 event disabled
    wr(3'd0, 32'h200);
    p0 = pulses;
    run(32'h31, 13);
    rd(3'd1, 32'd4, "R9");
    check(pulses - p0, 0, "R10");
    // R9 wrap off: no fold
    wr(3'd0, 32'h200);
    run(32'h1, 13);
    rd(3'd1, 32'd104, "R9");
    // R7 restart while counting wins over the increment
    wr(3'd1, 32'd5000);
    wr(3'd0, 32'h1);
    idle(3);
    wr(3'd0, 32'h201);
    idle(2);
    wr(3'd0, 32'h800);
    idle(2);
    rd(3'd1, 32'd24, "R7");
    // R8 load while counting wins over the increment
    wr(3'd0, 32'h1);
    idle(3);
    wr(3'd1, 32'd1000);
    idle(1);
    wr(3'd0, 32'h800);
    idle(2);
    rd(3'd1, 32'd1016, "R8");
    rd(3'd0, 32'h0, "R7");
    idle(3);
    finish_up();
  end
endmodule